// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two unsigned operands and a single carry-in, returning the sum and a final carry-out. It has no clock or state: the result follows the inputs combinationally. Inside, the operand width is cut into equal slices. Every carry inside a slice comes straight from a flat sum-of-products over the per-bit generate (both bits set) and propagate (bits differ) terms and the slice's own carry-in, so no carry ripples inside a slice. The slices then hand their carry-outs upward one to the next.

The width defaults to 32 bits in four 8-bit slices. Both are parameters, and the product terms are built by nested generate loops, so a new slice size needs no hand-written equations. Elaboration stops with an error when the width is not a whole multiple of the slice size. The data path is a plain combinational function with nothing to hand off, so it has no valid/ready handshake. It is meant to sit between registers of the surrounding pipeline.

Top module: `cla_adder`

## Requirements
- R1: With carry_in = 0, {carry_out, sum} equals op_a + op_b as an unsigned (WIDTH+1)-bit value for every operand pair.
- R2: With carry_in = 1, {carry_out, sum} equals op_a + op_b + 1.
- R3: When every bit position propagates (op_a XOR op_b all ones), carry_in reaches carry_out through every slice: sum is all ones XOR'd with carry_in fanned to bit 0 only as an increment, i.e. op_a = all ones, op_b = 0, carry_in = 1 gives sum = 0 and carry_out = 1.
- R4: A carry generated in the top bit of one slice enters the bottom bit of the next slice: op_a = 0x000000FF, op_b = 0x00000001, carry_in = 0 gives sum = 0x00000100, carry_out = 0.
- R5: At a bit where both operands are 1 (generate), the carry out of that bit is 1 whatever its carry-in; with op_a = op_b the result is op_a shifted left by one with carry_in in bit 0.
- R6: All-zero operands with carry_in = 0 give sum = 0 and carry_out = 0.
- R7: carry_out is the carry leaving the most significant slice: op_a = op_b = 0x80000000 gives carry_out = 1 and sum = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
The two functions that meet on one set of inputs are the local carry generate inside a slice and the long propagate chain that crosses slice boundaries. Operand pairs such as all ones plus carry-in, or a generate at the top of one slice feeding propagates in the next, make both act together. Each pair is judged against an exact integer addition done in the bench, together with alternating-bit and random operands under both carry-in values.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned CLA_DEF_WIDTH = 32;
  localparam int unsigned CLA_DEF_GROUP = 8;

  // one bit's lookahead terms
  typedef struct packed {
    logic gen;
    logic prop;
  } gp_t;
endpackage

// File: rtl/cla_pg.sv
module cla_pg #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] g_o,
  output logic [N-1:0] p_o
);
  import cla_pkg::*;

  gp_t [N-1:0] terms;

  for (genvar k = 0; k < N; k++) begin : g_bit
    assign terms[k].gen  = a_i[k] & b_i[k];
    assign terms[k].prop = a_i[k] ^ b_i[k];
    assign g_o[k] = terms[k].gen;
    assign p_o[k] = terms[k].prop;
  end

  // a bit can never both create and pass a carry
  always_comb begin
    assert_gp_exclusive_R5: assert ((g_o & p_o) == '0)
      else $error("generate and propagate overlap");
  end
endmodule

// File: rtl/cla_group_carry.sv
module cla_group_carry #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  input  logic         cin_i,
  output logic [N-1:0] cout_o
);
  // cout_o[i] is the carry leaving bit i, flattened to one OR of ANDs
  for (genvar i = 0; i < N; i++) begin : g_carry
    logic [i+1:0] prod;
    for (genvar j = 0; j <= i; j++) begin : g_term
      if (j == i) begin : g_own
        assign prod[j] = g_i[j];
      end else begin : g_chain
        assign prod[j] = g_i[j] & (&p_i[i:j+1]);
      end
    end
    assign prod[i+1] = cin_i & (&p_i[i:0]);
    assign cout_o[i] = |prod;
  end

  // a fully propagating slice passes its carry-in unchanged
  always_comb begin
    if (&p_i) begin
      assert_prop_chain_R3: assert (cout_o[N-1] == cin_i)
        else $error("propagate chain broken");
    end
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         c_i,
  output logic [N-1:0] s_o,
  output logic         c_o
);
  logic [N-1:0] gen, prop, cout, cin_bit;

  cla_pg #(.N(N)) u_pg (
    .a_i(a_i), .b_i(b_i), .g_o(gen), .p_o(prop)
  );

  cla_group_carry #(.N(N)) u_carry (
    .g_i(gen), .p_i(prop), .cin_i(c_i), .cout_o(cout)
  );

  for (genvar k = 0; k < N; k++) begin : g_cin
    if (k == 0) begin : g_lsb
      assign cin_bit[k] = c_i;
    end else begin : g_up
      assign cin_bit[k] = cout[k-1];
    end
  end

  assign s_o = prop ^ cin_bit;
  assign c_o = cout[N-1];

  logic [N:0] slice_ref;
  always_comb begin
    slice_ref = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, c_i};
    assert_group_sum_R1: assert ({c_o, s_o} == slice_ref)
      else $error("slice result wrong");
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned WIDTH = cla_pkg::CLA_DEF_WIDTH,
  parameter int unsigned GROUP = cla_pkg::CLA_DEF_GROUP
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int unsigned NGRP = WIDTH / GROUP;

  if ((WIDTH % GROUP) != 0 || GROUP < 1) begin : g_bad_cfg
    $error("WIDTH must be a whole multiple of GROUP");
  end

  logic [NGRP:0] link;
  assign link[0] = carry_in;

  for (genvar s = 0; s < NGRP; s++) begin : g_slice
    cla_group #(.N(GROUP)) u_grp (
      .a_i(op_a[s*GROUP +: GROUP]),
      .b_i(op_b[s*GROUP +: GROUP]),
      .c_i(link[s]),
      .s_o(sum[s*GROUP +: GROUP]),
      .c_o(link[s+1])
    );
  end

  assign carry_out = link[NGRP];

  logic [WIDTH:0] full_ref;
  always_comb begin
    full_ref = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    assert_total_R2: assert ({carry_out, sum} == full_ref)
      else $error("adder result wrong");
    if (&(op_a ^ op_b)) begin
      assert_full_chain_R3: assert (carry_out == carry_in)
        else $error("carry lost across slices");
    end
  end
endmodule

// File: tb/tb_cla_adder.sv
module tb_cla_adder;
  localparam int unsigned W = 32;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ci;
    logic [W:0]   exp;
    string        req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic carry_in = 1'b0;
  logic [W-1:0] sum;
  logic carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #2 clk = ~clk;

  cla_adder dut (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out)
  );

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic ci, input string req);
    item_t it;
    @(posedge clk);
    op_a = a; op_b = b; carry_in = ci;
    it.a = a; it.b = b; it.ci = ci; it.req = req;
    it.exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    sb.push_back(it);
  endtask

  // monitor: one result per cycle, taken at the falling edge
  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if ({carry_out, sum} !== it.exp) begin
        errors++;
        $display("FAIL %s a=%h b=%h ci=%0b got=%h expected=%h",
                 it.req, it.a, it.b, it.ci, {carry_out, sum}, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R6: idle inputs give zero result
    send('0, '0, 1'b0, "R6");
    // R1: zero carry-in patterns
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R1");
    send(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R1");
    send(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, "R1");
    send(32'h1234_5678, 32'h0FED_CBA9, 1'b0, "R1");
    // R2: carry-in set
    send('0, '0, 1'b1, "R2");
    send(32'h5555_5555, 32'h5555_5555, 1'b1, "R2");
    send(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R2");
    // R3: carry through every slice
    send(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R3");
    send(32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b1, "R3");
    send(32'h0000_0001, 32'hFFFF_FFFF, 1'b0, "R3");
    // R4: carry across a slice boundary
    send(32'h0000_00FF, 32'h0000_0001, 1'b0, "R4");
    send(32'h00FF_FF80, 32'h0000_0080, 1'b0, "R4");
    // R5: generate at every set bit
    send(32'h8421_0F0F, 32'h8421_0F0F, 1'b0, "R5");
    send(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, "R5");
    // R7: carry out of the top slice
    send(32'h8000_0000, 32'h8000_0000, 1'b0, "R7");
    send(32'hFF00_0000, 32'h0100_0000, 1'b0, "R7");
    for (int n = 0; n < 200; n++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      send(ra, rb, n[0], n[0] ? "R2" : "R1");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule